// File: doc/BRIEF.md
# Descriptor Ring Pointer Engine

This block runs two descriptor rings, one for receive and one for transmit, that share a single memory region. It keeps one index per ring. It forms each descriptor's bus address from a page byte, a 1 KB aligned base and the ring's index. It fetches and writes back descriptors through a single-beat request/grant master port. Each ring holds one fetched descriptor on chip until a completion strobe closes it. The descriptor contents, the data-buffer transfers and the bus protocol itself are not handled here.

Software starts ring processing with a prompt pulse, which stands for a write of any value to a prompt register. The prompt reaches both rings. A ring that is idle fetches its next descriptor. A ring that still owns a descriptor carries on as if no prompt had come. After a closed descriptor has been written back, the ring's index steps forward by one, wraps at the programmed ring size, and the ring waits for the next prompt. Both indices can be read back at all times. Clearing the master enable returns both rings to idle and sets both indices to zero.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset both rings are idle, both indices are zero, `m_req` is low and both `*_active` outputs are low.
- R2: A prompt with `mstr_en` high moves every idle ring to a fetch state. From the next cycle that ring requests a read (`m_write`=0) of the descriptor at its current index.
- R3: A prompt has no effect on a ring that is fetching, holding or writing back a descriptor. Its index, its held descriptor and its progress do not change.
- R4: `m_addr` is {`ring_page`, `ring_base`, ring bit, index, 3'b000}. The ring bit is address bit 9 (0 = receive, 1 = transmit). The index occupies bits [8:3]. As a result, the transmit ring starts 64*8 bytes above the receive ring.
- R5: When a fetch is granted, `m_rdata` is captured. The next cycle `*_active` goes high, and `*_desc` shows the captured value, unchanged, until that ring is closed.
- R6: A close strobe on an active ring starts a write-back request (`m_write`=1, `m_wdata` = the held descriptor). When that request is granted, the index advances by one and the ring becomes idle.
- R7: A ring uses 2^`ring_size_log2` entries. Values above 6 are treated as 6. The index wraps to zero modulo that size.
- R8: `ptr_rdback` carries the receive index in bits [5:0] and the transmit index in bits [13:8]. All other bits are zero.
- R9: While `mstr_en` is low, both indices are forced to zero, both rings go idle at the next edge, no request is made and prompts are ignored.
- R10: If both rings want the port and no request is outstanding, the receive ring goes first. An ungranted request keeps its address, direction and data until `m_gnt`.
- R11: A close strobe on a ring that is not active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mstr_en | input | 1 | Master enable; low clears both indices and idles both rings |
| ring_page | input | 8 | Address bits [31:24] |
| ring_base | input | 14 | Ring region address bits [23:10] |
| ring_size_log2 | input | 3 | Log2 of entries per ring (0..6, larger clamps to 6) |
| prompt | input | 1 | One-cycle software prompt to both rings |
| rx_close | input | 1 | Completion strobe for the active receive descriptor |
| tx_close | input | 1 | Completion strobe for the active transmit descriptor |
| ptr_rdback | output | 16 | Index readback: receive [5:0], transmit [13:8] |
| m_req | output | 1 | Master request, single beat |
| m_write | output | 1 | 1 = descriptor write-back, 0 = descriptor fetch |
| m_addr | output | 32 | Descriptor byte address |
| m_wdata | output | 64 | Descriptor written back |
| m_gnt | input | 1 | Grant; the beat completes in this cycle |
| m_rdata | input | 64 | Fetched descriptor, valid with `m_gnt` on a read |
| rx_active | output | 1 | Receive ring holds an open descriptor |
| tx_active | output | 1 | Transmit ring holds an open descriptor |
| rx_desc | output | 64 | Held receive descriptor |
| tx_desc | output | 64 | Held transmit descriptor |

## Verification
A wrong index shows up at once on `ptr_rdback`. It also shows up on `m_addr` at the ring's next request, since the address is built directly from the index. A wrong ring state appears within one cycle on `m_req`, `m_write` or `*_active`. A bad arbitration lock appears as an address or direction change while a request is still waiting for `m_grant`. A stale or corrupted held descriptor is visible on `*_desc` while the ring is active, and again on `m_wdata` at write-back. For this reason, every one of these outputs is compared against the model on every clock, instead of only at the end of a transfer.

// File: rtl/drp_pkg.sv
// Package: shared types for the descriptor ring pointer engine.
// Assumes exactly two rings, receive (index 0) and transmit (index 1).
package drp_pkg;
    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_FETCH  = 2'd1,
        RS_ACTIVE = 2'd2,
        RS_WBACK  = 2'd3
    } ring_st_e;

    localparam int RING_RX = 0;
    localparam int RING_TX = 1;
    localparam int N_RINGS = 2;
endpackage

// File: rtl/drp_ring_ctrl.sv
// Module: drp_ring_ctrl
// One ring's state machine: idle -> fetch -> active -> write-back -> idle.
// It holds the ring index and the single cached descriptor.
// Assumes: bus_gnt is high only while this ring's request is selected,
// and idx_mask is 2^n-1.
module drp_ring_ctrl
    import drp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DESC_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              prompt,
    input  logic              close,
    input  logic [IDX_W-1:0]  idx_mask,
    input  logic              bus_gnt,
    input  logic [DESC_W-1:0] bus_rdata,
    output logic              want,
    output logic              is_wb,
    output logic [IDX_W-1:0]  idx,
    output logic [DESC_W-1:0] desc,
    output logic              active
);
    ring_st_e          st_q, st_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DESC_W-1:0] desc_q;

    // Next state: prompts count only in idle, closes only while active
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_IDLE:   if (prompt)  st_d = RS_FETCH;
            RS_FETCH:  if (bus_gnt) st_d = RS_ACTIVE;
            RS_ACTIVE: if (close)   st_d = RS_WBACK;
            RS_WBACK:  if (bus_gnt) st_d = RS_IDLE;
            default:                st_d = RS_IDLE;
        endcase
        if (!en) st_d = RS_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    // Ring index: cleared while disabled, stepped after a granted write-back
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            idx_q <= '0;
        else if (st_q == RS_WBACK && bus_gnt)
            idx_q <= (idx_q + 1'b1) & idx_mask;
    end

    // Cached descriptor, loaded on a granted fetch
    always_ff @(posedge clk) begin
        if (!rst_n)
            desc_q <= '0;
        else if (en && st_q == RS_FETCH && bus_gnt)
            desc_q <= bus_rdata;
    end

    assign want   = (st_q == RS_FETCH) || (st_q == RS_WBACK);
    assign is_wb  = (st_q == RS_WBACK);
    assign active = (st_q == RS_ACTIVE);
    assign idx    = idx_q;
    assign desc   = desc_q;

    // R2
    prompt_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && prompt && st_q == RS_IDLE) |=> (st_q == RS_FETCH));

    // R5
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_ACTIVE && !close && en) |=> (active && $stable(desc_q)));

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !(st_q == RS_WBACK && bus_gnt)) |=> $stable(idx_q));

    // R11
    close_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && close && st_q == RS_IDLE && !prompt) |=> (st_q == RS_IDLE));
endmodule

// File: rtl/drp_arbiter.sv
// Module: drp_arbiter
// Shares the single-beat master port between the two rings.
// The receive ring wins when the port is free. An ungranted request
// stays locked to its owner until the grant arrives.
// Assumes: a ring's want stays high until it is granted, or drops
// only when the engine is disabled.
module drp_arbiter
    import drp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RINGS-1:0] want,
    input  logic               bus_gnt,
    output logic               m_req,
    output logic               sel,
    output logic [N_RINGS-1:0] ring_gnt
);
    logic locked_q;
    logic lock_sel_q;

    // Owner choice: the locked owner first, otherwise receive before transmit
    always_comb begin
        sel      = locked_q ? lock_sel_q : !want[RING_RX];
        m_req    = |want;
        ring_gnt = '0;
        ring_gnt[RING_RX] = bus_gnt && m_req && !sel;
        ring_gnt[RING_TX] = bus_gnt && m_req &&  sel;
    end

    // Lock the owner while its request waits for a grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q   <= 1'b0;
            lock_sel_q <= 1'b0;
        end else begin
            locked_q   <= m_req && !bus_gnt;
            lock_sel_q <= sel;
        end
    end
endmodule

// File: rtl/desc_ring_engine.sv
// Module: desc_ring_engine (top)
// Two descriptor rings in one region: receive at offset 0, transmit one
// whole ring (2^IDX_W descriptors) higher. It builds descriptor
// addresses, runs fetch and write-back through the master port, and
// exposes both indices for readback.
// Assumes DESC_BYTES is a power of two and IDX_W <= TX_LSB.
module desc_ring_engine
    import drp_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int DESC_W     = 64,
    parameter int DESC_BYTES = 8,
    parameter int PAGE_W     = 8,
    parameter int BASE_W     = 14,
    parameter int RB_W       = 16,
    parameter int TX_LSB     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mstr_en,
    input  logic [PAGE_W-1:0]    ring_page,
    input  logic [BASE_W-1:0]    ring_base,
    input  logic [$clog2(IDX_W+1)-1:0] ring_size_log2,
    input  logic                 prompt,
    input  logic                 rx_close,
    input  logic                 tx_close,
    output logic [RB_W-1:0]      ptr_rdback,
    output logic                 m_req,
    output logic                 m_write,
    output logic [PAGE_W+BASE_W+1+IDX_W+$clog2(DESC_BYTES)-1:0] m_addr,
    output logic [DESC_W-1:0]    m_wdata,
    input  logic                 m_gnt,
    input  logic [DESC_W-1:0]    m_rdata,
    output logic                 rx_active,
    output logic                 tx_active,
    output logic [DESC_W-1:0]    rx_desc,
    output logic [DESC_W-1:0]    tx_desc
);
    localparam int OFF_W  = $clog2(DESC_BYTES);
    localparam int SZ_W   = $clog2(IDX_W + 1);

    logic [IDX_W-1:0]   idx_mask;
    logic [N_RINGS-1:0] want, is_wb, act, ring_gnt, close_v;
    logic [IDX_W-1:0]   idx_a  [N_RINGS];
    logic [DESC_W-1:0]  desc_a [N_RINGS];
    logic               sel;

    // Ring size mask, clamping out-of-range sizes to the full ring
    always_comb begin
        logic [SZ_W-1:0] sz_eff;
        sz_eff   = (ring_size_log2 > SZ_W'(IDX_W)) ? SZ_W'(IDX_W) : ring_size_log2;
        idx_mask = IDX_W'(((IDX_W+1)'(1) << sz_eff) - 1'b1);
    end

    assign close_v[RING_RX] = rx_close;
    assign close_v[RING_TX] = tx_close;

    for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
        drp_ring_ctrl #(.IDX_W(IDX_W), .DESC_W(DESC_W)) u_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (mstr_en),
            .prompt   (prompt),
            .close    (close_v[r]),
            .idx_mask (idx_mask),
            .bus_gnt  (ring_gnt[r]),
            .bus_rdata(m_rdata),
            .want     (want[r]),
            .is_wb    (is_wb[r]),
            .idx      (idx_a[r]),
            .desc     (desc_a[r]),
            .active   (act[r])
        );
    end

    drp_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .want    (want),
        .bus_gnt (m_gnt),
        .m_req   (m_req),
        .sel     (sel),
        .ring_gnt(ring_gnt)
    );

    // Master port fields taken from the selected ring
    always_comb begin
        m_write = is_wb[sel];
        m_wdata = desc_a[sel];
        m_addr  = {ring_page, ring_base, sel, idx_a[sel], {OFF_W{1'b0}}};
    end

    // Index readback layout
    assign ptr_rdback = RB_W'(idx_a[RING_RX]) | (RB_W'(idx_a[RING_TX]) << TX_LSB);

    assign rx_active = act[RING_RX];
    assign tx_active = act[RING_TX];
    assign rx_desc   = desc_a[RING_RX];
    assign tx_desc   = desc_a[RING_TX];

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_gnt && mstr_en) |=>
        (m_req && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));

    // R9
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mstr_en |=> (ptr_rdback == '0 && !m_req && !rx_active && !tx_active));
endmodule

// File: tb/desc_ring_engine_tb.sv
// Bench: behavioural reference model compared on every clock.
module desc_ring_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mstr_en = 1'b0;
    logic [7:0]  ring_page = 8'h00;
    logic [13:0] ring_base = 14'h0;
    logic [2:0]  ring_size_log2 = 3'd6;
    logic        prompt = 1'b0, rx_close = 1'b0, tx_close = 1'b0;
    logic [15:0] ptr_rdback;
    logic        m_req, m_write, m_gnt = 1'b0;
    logic [31:0] m_addr;
    logic [63:0] m_wdata, m_rdata = '0;
    logic        rx_active, tx_active;
    logic [63:0] rx_desc, tx_desc;

    int n_chk = 0, n_fail = 0, wd = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    // Model state: 0 idle, 1 fetch, 2 active, 3 write-back
    int          ms [2];
    int          mi [2];
    logic [63:0] md [2];
    bit          lk;
    int          ls;

    always #10 clk = ~clk;

    desc_ring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .mstr_en(mstr_en), .ring_page(ring_page),
        .ring_base(ring_base), .ring_size_log2(ring_size_log2), .prompt(prompt),
        .rx_close(rx_close), .tx_close(tx_close), .ptr_rdback(ptr_rdback),
        .m_req(m_req), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_gnt(m_gnt), .m_rdata(m_rdata), .rx_active(rx_active),
        .tx_active(tx_active), .rx_desc(rx_desc), .tx_desc(tx_desc)
    );

    function automatic bit e_want(int r);
        return ms[r] == 1 || ms[r] == 3;
    endfunction
    function automatic bit e_req();
        return e_want(0) || e_want(1);
    endfunction
    function automatic int e_sel();   // R10: receive first unless locked
        if (lk) return ls;
        return e_want(0) ? 0 : 1;
    endfunction

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Reference model update at each active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 2; r++) begin ms[r] = 0; mi[r] = 0; md[r] = '0; end
            lk = 0; ls = 0;
        end else begin
            bit req_now;
            int sel_now;
            int szn;
            req_now = e_req();
            sel_now = e_sel();
            szn = (ring_size_log2 > 6) ? 6 : int'(ring_size_log2);   // R7
            for (int r = 0; r < 2; r++) begin
                bit g;
                bit cl;
                g  = m_gnt && req_now && sel_now == r;
                cl = (r == 0) ? rx_close : tx_close;
                if (!mstr_en) begin          // R9
                    ms[r] = 0; mi[r] = 0;
                end else begin
                    case (ms[r])
                        0: if (prompt) ms[r] = 1;                 // R2, R3
                        1: if (g) begin md[r] = m_rdata; ms[r] = 2; end
                        2: if (cl) ms[r] = 3;                     // R11
                        default: if (g) begin mi[r] = (mi[r] + 1) % (1 << szn); ms[r] = 0; end
                    endcase
                end
            end
            lk = req_now && !m_gnt;
            ls = sel_now;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
            finish_run();
        end
    end

    task automatic compare_all();
        int s;
        logic [31:0] ea;
        s = e_sel();
        chk("R2 R6 R9 R10", "m_req", 64'(m_req), 64'(e_req()));
        chk("R8 R7 R9", "ptr_rdback", 64'(ptr_rdback), 64'((mi[0] & 63) | ((mi[1] & 63) << 8)));
        chk("R5 R11", "rx_active", 64'(rx_active), 64'(ms[0] == 2));
        chk("R5 R11", "tx_active", 64'(tx_active), 64'(ms[1] == 2));
        if (ms[0] == 2) chk("R5 R3", "rx_desc", rx_desc, md[0]);
        if (ms[1] == 2) chk("R5 R3", "tx_desc", tx_desc, md[1]);
        if (e_req()) begin
            ea = {ring_page, ring_base, s[0], 6'(mi[s]), 3'b000};
            chk("R4 R10", "m_addr", 64'(m_addr), 64'(ea));
            chk("R2 R6", "m_write", 64'(m_write), 64'(ms[s] == 3));
            if (ms[s] == 3) chk("R6", "m_wdata", m_wdata, md[s]);
        end
    endtask

    initial begin
        for (int r = 0; r < 2; r++) begin ms[r] = 0; mi[r] = 0; md[r] = '0; end
        lk = 0; ls = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "m_req", 64'(m_req), 64'(0));
        chk("R1", "ptr_rdback", 64'(ptr_rdback), 64'(0));
        chk("R1", "rx_active", 64'(rx_active), 64'(0));
        chk("R1", "tx_active", 64'(tx_active), 64'(0));
        rst_n = 1'b1;
        mstr_en = 1'b1;
        for (int cyc = 0; cyc < 4200; cyc++) begin
            int ph;
            @(negedge clk);
            compare_all();
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            ph = cyc / 600;
            case (ph)
                0: ring_size_log2 = 3'd6;
                1: ring_size_log2 = 3'd2;
                2: ring_size_log2 = 3'd0;
                3: ring_size_log2 = 3'd7;
                4: ring_size_log2 = 3'd3;
                5: ring_size_log2 = 3'd1;
                default: ring_size_log2 = 3'd6;
            endcase
            ring_page = 8'hA5 ^ 8'(ph);
            ring_base = 14'h1234 + 14'(ph * 1001);
            prompt    = (ph == 0) ? (lfsr[1:0] == 0) : (lfsr[3:0] == 0);
            m_gnt     = lfsr[5:4] != 2'b00;
            rx_close  = lfsr[8:6] == 3'b000;
            tx_close  = lfsr[11:9] == 3'b000;
            m_rdata   = {lfsr, ~lfsr ^ 32'(cyc)};
            mstr_en   = !(ph >= 4 && lfsr[20:15] == 6'd0);
        end
        finish_run();
    end
endmodule